// File: doc/BRIEF.md
# Machine-Mode Performance Counter File

This block keeps the hardware performance counters of a processor hart and serves them through a single CSR access port. It has eight 64-bit counters: a free-running cycle counter, a retired-instruction counter, and six generic counters. The generic counters are numbered 3 to 8. Each generic counter has its own event-select register, which picks one of 22 numbered event pulses. A counter-inhibit register stops individual counters. Two counter-enable registers, one written from machine mode and one from supervisor mode, decide whether lower privilege levels may read the read-only shadow copies of the counters.

The surrounding pipeline drives a 22-bit vector of single-cycle event pulses and a per-cycle retire count. It presents one CSR access per cycle, made of an address, an operation, write data and the current privilege level. Read data and the illegal-access flag come back combinationally in the same cycle. A write takes effect at the next clock edge. The CSR port has no back-pressure: an access is complete in the cycle in which `csr_valid_i` is high. The caller turns `csr_illegal_o` into a trap.

Top module: `hpm_counter_unit`

## Requirements
- R1: The cycle counter (index 0) adds 1 on every clock edge unless it is inhibited. All 64-bit counters wrap modulo 2^64.
- R2: The retired-instruction counter (index 2) adds the value of `retire_cnt_i` (0 to 2) on every clock edge unless it is inhibited.
- R3: Generic counter N (N = 3..8) adds 1 on a clock edge when its selector holds a code k in 1..22 and `event_i[k-1]` is high. It does not respond to any other event bit.
- R4: An event-select register (address 0x320+N) stores only the low 5 bits of the written value and reads them back zero-extended. A code of 0 or of 23..31 never increments the counter.
- R5: The inhibit register (0x320) stops the cycle counter with bit 0, the retired-instruction counter with bit 2, and generic counter N with bit N. A value of 0 in a bit lets that counter increment. The inhibit, enable and select registers all reset to 0.
- R6: For counter index i, the low 32 bits are at 0xB00+i and the high 32 bits at 0xB80+i. Indices 1 and 9..31 read 0 and ignore writes. Selectors 0x329..0x33F behave the same way.
- R7: A CSR write, set or clear to either half of a counter in a given cycle replaces that cycle's increment, so the counter holds exactly the written value afterwards.
- R8: `csr_op_i` is coded 0 read, 1 write, 2 set bits, 3 clear bits. Read data is always the value before the access.
- R9: Registers at 0x3xx and 0xBxx need privilege 3 (machine). The supervisor enable register at 0x106 needs privilege 1 or higher. Privilege is coded 0 user, 1 supervisor, 3 machine.
- R10: The shadows at 0xC00+i and 0xC80+i return the low and high halves of counter i. Machine mode may always read them. Supervisor mode needs bit i of the machine enable register (0x306). User mode needs bit i in both enable registers.
- R11: The illegal flag rises only with `csr_valid_i`. It rises for any non-read operation on a shadow and for every denied access. An illegal access changes no register.
- R12: The inhibit and both enable registers implement bits 0 and 2..8 only. All other bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| event_i | input | 22 | Event pulses; bit k-1 carries event code k |
| retire_cnt_i | input | 2 | Instructions retired this cycle (0 to 2) |
| csr_valid_i | input | 1 | A CSR access is presented this cycle |
| csr_addr_i | input | 12 | CSR address |
| csr_op_i | input | 2 | 0 read, 1 write, 2 set, 3 clear |
| csr_wdata_i | input | 32 | Write data or bit mask |
| csr_priv_i | input | 2 | Privilege of the access: 0 user, 1 supervisor, 3 machine |
| csr_rdata_o | output | 32 | Value of the addressed register before the access |
| csr_illegal_o | output | 1 | The access is denied and has no effect |

## Verification
The properties take for granted that `retire_cnt_i` never exceeds 2 and that the privilege code 2 never appears. They also assume that a set or clear of a counter counts as a write even when the mask is zero. The stimulus keeps to these limits: it drives retire counts only from 0, 1 and 2, uses only privilege codes 0, 1 and 3, and changes the counters only through explicit write, set or clear accesses. Counting checks run with all other counters inhibited, so each expected value follows from the number of clock edges since the last write.

// File: rtl/hpm_pkg.sv
package hpm_pkg;

  typedef enum logic [3:0] {
    K_NONE, K_MEN, K_SEN, K_INH, K_SEL, K_CLO, K_CHI, K_SLO, K_SHI
  } csr_kind_e;

  localparam logic [1:0] OP_READ  = 2'd0;
  localparam logic [1:0] OP_WRITE = 2'd1;
  localparam logic [1:0] OP_SET   = 2'd2;
  localparam logic [1:0] OP_CLEAR = 2'd3;

  localparam logic [1:0] PRIV_U = 2'd0;
  localparam logic [1:0] PRIV_S = 2'd1;
  localparam logic [1:0] PRIV_M = 2'd3;

  localparam logic [11:0] ADDR_MEN  = 12'h306;
  localparam logic [11:0] ADDR_SEN  = 12'h106;
  localparam logic [11:0] ADDR_INH  = 12'h320;
  localparam logic [11:0] BASE_SEL  = 12'h320;
  localparam logic [11:0] BASE_CLO  = 12'hB00;
  localparam logic [11:0] BASE_CHI  = 12'hB80;
  localparam logic [11:0] BASE_SLO  = 12'hC00;
  localparam logic [11:0] BASE_SHI  = 12'hC80;

  localparam int FIRST_GEN = 3;

endpackage

// File: rtl/hpm_csr_decode.sv
module hpm_csr_decode
  import hpm_pkg::*;
#(
  parameter int HALF_W = 32
) (
  input  logic              csr_valid_i,
  input  logic [11:0]       csr_addr_i,
  input  logic [1:0]        csr_op_i,
  input  logic [1:0]        csr_priv_i,
  input  logic [HALF_W-1:0] men_i,
  input  logic [HALF_W-1:0] sen_i,
  output csr_kind_e         kind_o,
  output logic [4:0]        idx_o,
  output logic              illegal_o,
  output logic              wr_en_o
);

  logic       shadow;
  logic       en_ok;
  logic       priv_low;
  logic       read_only;
  logic       hit;

  assign idx_o = csr_addr_i[4:0];

  always_comb begin
    kind_o = K_NONE;
    if (csr_addr_i == ADDR_MEN)                                   kind_o = K_MEN;
    else if (csr_addr_i == ADDR_SEN)                              kind_o = K_SEN;
    else if (csr_addr_i == ADDR_INH)                              kind_o = K_INH;
    else if (csr_addr_i[11:5] == BASE_SEL[11:5] && idx_o >= 5'd3) kind_o = K_SEL;
    else if (csr_addr_i[11:5] == BASE_CLO[11:5])                  kind_o = K_CLO;
    else if (csr_addr_i[11:5] == BASE_CHI[11:5])                  kind_o = K_CHI;
    else if (csr_addr_i[11:5] == BASE_SLO[11:5])                  kind_o = K_SLO;
    else if (csr_addr_i[11:5] == BASE_SHI[11:5])                  kind_o = K_SHI;
  end

  assign shadow    = (kind_o == K_SLO) || (kind_o == K_SHI);
  assign priv_low  = csr_priv_i < csr_addr_i[9:8];
  assign read_only = (csr_addr_i[11:10] == 2'b11) && (csr_op_i != OP_READ);
  assign hit       = csr_valid_i && (kind_o != K_NONE);

  always_comb begin
    case (csr_priv_i)
      PRIV_M:  en_ok = 1'b1;
      PRIV_S:  en_ok = men_i[idx_o];
      default: en_ok = men_i[idx_o] & sen_i[idx_o];
    endcase
  end

  assign illegal_o = hit && (priv_low || read_only || (shadow && !en_ok));
  assign wr_en_o   = hit && !illegal_o && (csr_op_i != OP_READ);

endmodule

// File: rtl/hpm_event_mux.sv
module hpm_event_mux #(
  parameter int NUM_EVENTS = 22,
  parameter int SEL_W      = 5
) (
  input  logic [SEL_W-1:0]      sel_i,
  input  logic [NUM_EVENTS-1:0] events_i,
  output logic                  hit_o
);

  always_comb begin
    hit_o = 1'b0;
    for (int k = 1; k <= NUM_EVENTS; k++) begin
      if (int'(sel_i) == k) hit_o = events_i[k-1];
    end
  end

endmodule

// File: rtl/hpm_counter.sv
module hpm_counter #(
  parameter int HALF_W = 32,
  parameter int INC_W  = 1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                inc_en_i,
  input  logic [INC_W-1:0]    inc_amt_i,
  input  logic                wr_lo_i,
  input  logic                wr_hi_i,
  input  logic [HALF_W-1:0]   wdata_i,
  output logic [2*HALF_W-1:0] count_o
);

  localparam int CNT_W = 2 * HALF_W;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      count_o <= '0;
    end else if (wr_lo_i || wr_hi_i) begin
      if (wr_lo_i) count_o[HALF_W-1:0]     <= wdata_i;
      if (wr_hi_i) count_o[CNT_W-1:HALF_W] <= wdata_i;
    end else if (inc_en_i) begin
      count_o <= count_o + CNT_W'(inc_amt_i);
    end
  end

endmodule

// File: rtl/hpm_counter_unit.sv
module hpm_counter_unit
  import hpm_pkg::*;
#(
  parameter int HALF_W     = 32,
  parameter int NUM_GEN    = 6,
  parameter int NUM_EVENTS = 22,
  parameter int SEL_W      = 5,
  parameter int RET_W      = 2
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [NUM_EVENTS-1:0] event_i,
  input  logic [RET_W-1:0]      retire_cnt_i,
  input  logic                  csr_valid_i,
  input  logic [11:0]           csr_addr_i,
  input  logic [1:0]            csr_op_i,
  input  logic [HALF_W-1:0]     csr_wdata_i,
  input  logic [1:0]            csr_priv_i,
  output logic [HALF_W-1:0]     csr_rdata_o,
  output logic                  csr_illegal_o
);

  localparam int CNT_W    = 2 * HALF_W;
  localparam int LAST_GEN = FIRST_GEN + NUM_GEN - 1;

  function automatic logic [HALF_W-1:0] impl_mask_f();
    logic [HALF_W-1:0] m;
    m    = '0;
    m[0] = 1'b1;
    for (int i = 2; i <= LAST_GEN; i++) m[i] = 1'b1;
    return m;
  endfunction

  localparam logic [HALF_W-1:0] IMPL_MASK = impl_mask_f();

  // control registers
  logic [HALF_W-1:0] men_q, sen_q, inh_q;
  logic [NUM_GEN-1:0][SEL_W-1:0] gen_sel;
  logic [NUM_GEN-1:0][CNT_W-1:0] gen_cnt;
  logic [NUM_GEN-1:0]            gen_wr;
  logic [CNT_W-1:0]              cyc_cnt, ins_cnt, cnt_rd;
  logic [SEL_W-1:0]              sel_rd;
  logic [HALF_W-1:0]             rd_val, wval;
  logic                          cyc_wr_lo, cyc_wr_hi, ins_wr_lo, ins_wr_hi;
  logic                          cyc_wr, ins_wr;

  csr_kind_e  kind;
  logic [4:0] idx;
  logic       wr_en;

  hpm_csr_decode #(.HALF_W(HALF_W)) u_decode (
    .csr_valid_i (csr_valid_i),
    .csr_addr_i  (csr_addr_i),
    .csr_op_i    (csr_op_i),
    .csr_priv_i  (csr_priv_i),
    .men_i       (men_q),
    .sen_i       (sen_q),
    .kind_o      (kind),
    .idx_o       (idx),
    .illegal_o   (csr_illegal_o),
    .wr_en_o     (wr_en)
  );

  // read path: value before the access
  always_comb begin
    cnt_rd = '0;
    sel_rd = '0;
    if (idx == 5'd0) cnt_rd = cyc_cnt;
    if (idx == 5'd2) cnt_rd = ins_cnt;
    for (int g = 0; g < NUM_GEN; g++) begin
      if (int'(idx) == FIRST_GEN + g) begin
        cnt_rd = gen_cnt[g];
        sel_rd = gen_sel[g];
      end
    end
  end

  always_comb begin
    case (kind)
      K_MEN:        rd_val = men_q;
      K_SEN:        rd_val = sen_q;
      K_INH:        rd_val = inh_q;
      K_SEL:        rd_val = HALF_W'(sel_rd);
      K_CLO, K_SLO: rd_val = cnt_rd[HALF_W-1:0];
      K_CHI, K_SHI: rd_val = cnt_rd[CNT_W-1:HALF_W];
      default:      rd_val = '0;
    endcase
  end

  assign csr_rdata_o = rd_val;

  // write value after read-modify-write
  always_comb begin
    case (csr_op_i)
      OP_SET:   wval = rd_val | csr_wdata_i;
      OP_CLEAR: wval = rd_val & ~csr_wdata_i;
      default:  wval = csr_wdata_i;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      men_q <= '0;
      sen_q <= '0;
      inh_q <= '0;
    end else if (wr_en) begin
      if (kind == K_MEN) men_q <= wval & IMPL_MASK;
      if (kind == K_SEN) sen_q <= wval & IMPL_MASK;
      if (kind == K_INH) inh_q <= wval & IMPL_MASK;
    end
  end

  // fixed counters
  assign cyc_wr_lo = wr_en && (kind == K_CLO) && (idx == 5'd0);
  assign cyc_wr_hi = wr_en && (kind == K_CHI) && (idx == 5'd0);
  assign ins_wr_lo = wr_en && (kind == K_CLO) && (idx == 5'd2);
  assign ins_wr_hi = wr_en && (kind == K_CHI) && (idx == 5'd2);
  assign cyc_wr    = cyc_wr_lo | cyc_wr_hi;
  assign ins_wr    = ins_wr_lo | ins_wr_hi;

  hpm_counter #(.HALF_W(HALF_W), .INC_W(1)) u_cycle (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .inc_en_i  (!inh_q[0]),
    .inc_amt_i (1'b1),
    .wr_lo_i   (cyc_wr_lo),
    .wr_hi_i   (cyc_wr_hi),
    .wdata_i   (wval),
    .count_o   (cyc_cnt)
  );

  hpm_counter #(.HALF_W(HALF_W), .INC_W(RET_W)) u_instret (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .inc_en_i  (!inh_q[2]),
    .inc_amt_i (retire_cnt_i),
    .wr_lo_i   (ins_wr_lo),
    .wr_hi_i   (ins_wr_hi),
    .wdata_i   (wval),
    .count_o   (ins_cnt)
  );

  // generic event counters
  for (genvar g = 0; g < NUM_GEN; g++) begin : g_gen
    logic ev_hit, wr_lo, wr_hi;

    assign wr_lo     = wr_en && (kind == K_CLO) && (int'(idx) == FIRST_GEN + g);
    assign wr_hi     = wr_en && (kind == K_CHI) && (int'(idx) == FIRST_GEN + g);
    assign gen_wr[g] = wr_lo | wr_hi;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)
        gen_sel[g] <= '0;
      else if (wr_en && (kind == K_SEL) && (int'(idx) == FIRST_GEN + g))
        gen_sel[g] <= wval[SEL_W-1:0];
    end

    hpm_event_mux #(.NUM_EVENTS(NUM_EVENTS), .SEL_W(SEL_W)) u_mux (
      .sel_i    (gen_sel[g]),
      .events_i (event_i),
      .hit_o    (ev_hit)
    );

    hpm_counter #(.HALF_W(HALF_W), .INC_W(1)) u_cnt (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .inc_en_i  (ev_hit && !inh_q[FIRST_GEN+g]),
      .inc_amt_i (1'b1),
      .wr_lo_i   (wr_lo),
      .wr_hi_i   (wr_hi),
      .wdata_i   (wval),
      .count_o   (gen_cnt[g])
    );
  end

endmodule

// File: rtl/hpm_counter_unit_chk.sv
module hpm_counter_unit_chk #(
  parameter int HALF_W     = 32,
  parameter int NUM_GEN    = 6,
  parameter int NUM_EVENTS = 22,
  parameter int SEL_W      = 5,
  parameter int RET_W      = 2
) (
  input logic                          clk_i,
  input logic                          rst_ni,
  input logic                          csr_valid_i,
  input logic [3:0]                    addr_top,
  input logic [1:0]                    addr_mid,
  input logic [1:0]                    csr_op_i,
  input logic                          csr_illegal_o,
  input logic [RET_W-1:0]              retire_cnt_i,
  input logic [HALF_W-1:0]             men_q,
  input logic [HALF_W-1:0]             sen_q,
  input logic [HALF_W-1:0]             inh_q,
  input logic [2*HALF_W-1:0]           cyc_cnt,
  input logic [2*HALF_W-1:0]           ins_cnt,
  input logic                          cyc_wr,
  input logic                          ins_wr,
  input logic [NUM_GEN-1:0][SEL_W-1:0] gen_sel,
  input logic [NUM_GEN-1:0][2*HALF_W-1:0] gen_cnt,
  input logic [NUM_GEN-1:0]            gen_wr
);

  localparam int CNT_W = 2 * HALF_W;

  // R1
  cycle_inc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!inh_q[0] && !cyc_wr) |=> cyc_cnt == $past(cyc_cnt) + CNT_W'(1));

  // R5
  cycle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inh_q[0] && !cyc_wr) |=> $stable(cyc_cnt));

  // R2
  instret_add_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!inh_q[2] && !ins_wr) |=> ins_cnt == $past(ins_cnt) + CNT_W'($past(retire_cnt_i)));

  // R3
  gen_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !gen_wr[0] |=> (gen_cnt[0] - $past(gen_cnt[0])) <= CNT_W'(1));

  // R4
  reserved_sel_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int'(gen_sel[0]) > NUM_EVENTS && !gen_wr[0]) |=> $stable(gen_cnt[0]));

  // R11
  illegal_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    csr_illegal_o |-> csr_valid_i);

  // R11
  illegal_nochange_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    csr_illegal_o |=> $stable(inh_q) && $stable(men_q) && $stable(sen_q));

  // R11
  shadow_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (csr_valid_i && addr_top == 4'hC && addr_mid == 2'b00 && csr_op_i != 2'd0)
      |-> csr_illegal_o);

endmodule

bind hpm_counter_unit hpm_counter_unit_chk #(
  .HALF_W(HALF_W), .NUM_GEN(NUM_GEN), .NUM_EVENTS(NUM_EVENTS),
  .SEL_W(SEL_W), .RET_W(RET_W)
) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .csr_valid_i   (csr_valid_i),
  .addr_top      (csr_addr_i[11:8]),
  .addr_mid      (csr_addr_i[6:5]),
  .csr_op_i      (csr_op_i),
  .csr_illegal_o (csr_illegal_o),
  .retire_cnt_i  (retire_cnt_i),
  .men_q         (men_q),
  .sen_q         (sen_q),
  .inh_q         (inh_q),
  .cyc_cnt       (cyc_cnt),
  .ins_cnt       (ins_cnt),
  .cyc_wr        (cyc_wr),
  .ins_wr        (ins_wr),
  .gen_sel       (gen_sel),
  .gen_cnt       (gen_cnt),
  .gen_wr        (gen_wr)
);

// File: tb/hpm_counter_unit_bench.sv
module hpm_counter_unit_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [21:0] ev = '0;
  logic [1:0]  ret = '0;
  logic        vld = 1'b0;
  logic [11:0] addr = '0;
  logic [1:0]  op = '0;
  logic [31:0] wd = '0;
  logic [1:0]  priv = 2'd3;
  logic [31:0] rdata;
  logic        ill;

  int n_chk = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  hpm_counter_unit u_hpm_counter_unit (
    .clk_i         (clk),
    .rst_ni        (rst_n),
    .event_i       (ev),
    .retire_cnt_i  (ret),
    .csr_valid_i   (vld),
    .csr_addr_i    (addr),
    .csr_op_i      (op),
    .csr_wdata_i   (wd),
    .csr_priv_i    (priv),
    .csr_rdata_o   (rdata),
    .csr_illegal_o (ill)
  );

  // fields: op[80:79] addr[78:67] wdata[66:35] priv[34:33] exp[32:1] ill[0]
  localparam int NV = 37;
  localparam logic [80:0] VEC [NV] = '{
    {2'd1, 12'h320, 32'hFFFFFFFF, 2'd3, 32'h0,        1'b0},
    {2'd0, 12'h320, 32'h0,        2'd3, 32'h000001FD, 1'b0},
    {2'd1, 12'hB00, 32'h11111111, 2'd3, 32'h0,        1'b0},
    {2'd1, 12'hB80, 32'h22222222, 2'd3, 32'h0,        1'b0},
    {2'd0, 12'hB00, 32'h0,        2'd3, 32'h11111111, 1'b0},
    {2'd0, 12'hB80, 32'h0,        2'd3, 32'h22222222, 1'b0},
    {2'd1, 12'hB03, 32'hAAAA0003, 2'd3, 32'h0,        1'b0},
    {2'd0, 12'hB03, 32'h0,        2'd3, 32'hAAAA0003, 1'b0},
    {2'd1, 12'h323, 32'hFFFFFFE5, 2'd3, 32'h0,        1'b0},
    {2'd0, 12'h323, 32'h0,        2'd3, 32'h00000005, 1'b0},
    {2'd1, 12'hB09, 32'h00001234, 2'd3, 32'h0,        1'b0},
    {2'd0, 12'hB09, 32'h0,        2'd3, 32'h0,        1'b0},
    {2'd1, 12'h329, 32'h00000003, 2'd3, 32'h0,        1'b0},
    {2'd0, 12'h329, 32'h0,        2'd3, 32'h0,        1'b0},
    {2'd0, 12'hC00, 32'h0,        2'd0, 32'h0,        1'b1},
    {2'd1, 12'h306, 32'h00000005, 2'd3, 32'h0,        1'b0},
    {2'd0, 12'hC00, 32'h0,        2'd0, 32'h0,        1'b1},
    {2'd0, 12'hC00, 32'h0,        2'd1, 32'h11111111, 1'b0},
    {2'd1, 12'h106, 32'h00000001, 2'd1, 32'h0,        1'b0},
    {2'd0, 12'hC00, 32'h0,        2'd0, 32'h11111111, 1'b0},
    {2'd0, 12'hC02, 32'h0,        2'd0, 32'h0,        1'b1},
    {2'd1, 12'hC00, 32'h0,        2'd3, 32'h0,        1'b1},
    {2'd0, 12'hB00, 32'h0,        2'd3, 32'h11111111, 1'b0},
    {2'd0, 12'hB00, 32'h0,        2'd0, 32'h0,        1'b1},
    {2'd1, 12'h306, 32'h0,        2'd1, 32'h0,        1'b1},
    {2'd0, 12'h306, 32'h0,        2'd3, 32'h00000005, 1'b0},
    {2'd2, 12'h306, 32'hFFFFFFFF, 2'd3, 32'h0,        1'b0},
    {2'd0, 12'h306, 32'h0,        2'd3, 32'h000001FD, 1'b0},
    {2'd3, 12'hB03, 32'h0000FFFF, 2'd3, 32'h0,        1'b0},
    {2'd0, 12'hB03, 32'h0,        2'd3, 32'hAAAA0000, 1'b0},
    {2'd0, 12'hC83, 32'h0,        2'd3, 32'h0,        1'b0},
    {2'd0, 12'h106, 32'h0,        2'd0, 32'h0,        1'b1},
    {2'd0, 12'hC80, 32'h0,        2'd1, 32'h22222222, 1'b0},
    {2'd0, 12'hB01, 32'h0,        2'd3, 32'h0,        1'b0},
    {2'd0, 12'h106, 32'h0,        2'd3, 32'h00000001, 1'b0},
    {2'd1, 12'h320, 32'h0,        2'd0, 32'h0,        1'b1},
    {2'd0, 12'h320, 32'h0,        2'd3, 32'h000001FD, 1'b0}
  };

  function automatic string row_tag(int i);
    case (i)
      0, 1:                    return "R5 R12";
      2, 3, 4, 5, 6, 7:        return "R6";
      8, 9:                    return "R4";
      10, 11, 12, 13, 33:      return "R6";
      14, 16, 17, 19, 20, 32:  return "R10";
      21:                      return "R11";
      18, 23, 24, 31, 35:      return "R9";
      25, 34, 36:              return "R11";
      26, 27:                  return "R12 R8";
      default:                 return "R8";
    endcase
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // drive one access at the falling edge, check the combinational reply
  task automatic csr_do(logic [1:0] o, logic [11:0] a, logic [31:0] d,
                        logic [1:0] p, bit chk_rd, logic [31:0] exp,
                        logic exp_ill, string tag);
    @(negedge clk);
    vld = 1'b1; op = o; addr = a; wd = d; priv = p;
    #1;
    check(tag, {31'd0, ill}, {31'd0, exp_ill});
    if (chk_rd) check(tag, rdata, exp);
  endtask

  task automatic idle(int n, logic [21:0] e);
    repeat (n) begin
      @(negedge clk);
      vld = 1'b0; ev = e;
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R5: reset values
    csr_do(2'd0, 12'h320, 0, 2'd3, 1, 32'h0, 1'b0, "R5 reset inhibit");
    csr_do(2'd0, 12'h306, 0, 2'd3, 1, 32'h0, 1'b0, "R5 reset enable");
    csr_do(2'd0, 12'h324, 0, 2'd3, 1, 32'h0, 1'b0, "R5 reset selector");

    for (int i = 0; i < NV; i++) begin
      logic [80:0] v;
      v = VEC[i];
      csr_do(v[80:79], v[78:67], v[66:35], v[34:33],
             (v[80:79] == 2'd0) && !v[0], v[32:1], v[0], row_tag(i));
    end

    // R1, R7: cycle counting and write priority
    csr_do(2'd1, 12'h320, 32'h1FC, 2'd3, 0, 0, 1'b0, "R5");
    csr_do(2'd1, 12'hB00, 32'd100, 2'd3, 0, 0, 1'b0, "R7");
    csr_do(2'd0, 12'hB00, 0, 2'd3, 1, 32'd100, 1'b0, "R7 write over increment");
    csr_do(2'd0, 12'hB00, 0, 2'd3, 1, 32'd101, 1'b0, "R1 count");
    csr_do(2'd0, 12'hB00, 0, 2'd3, 1, 32'd102, 1'b0, "R1 count");
    // R1 wrap
    csr_do(2'd1, 12'hB80, 32'hFFFFFFFF, 2'd3, 0, 0, 1'b0, "R1");
    csr_do(2'd1, 12'hB00, 32'hFFFFFFFE, 2'd3, 0, 0, 1'b0, "R1");
    csr_do(2'd0, 12'hB00, 0, 2'd3, 1, 32'hFFFFFFFE, 1'b0, "R1 wrap lo");
    csr_do(2'd0, 12'hB80, 0, 2'd3, 1, 32'hFFFFFFFF, 1'b0, "R1 wrap hi");
    csr_do(2'd0, 12'hB00, 0, 2'd3, 1, 32'h0, 1'b0, "R1 wrapped lo");
    csr_do(2'd0, 12'hB80, 0, 2'd3, 1, 32'h0, 1'b0, "R1 wrapped hi");
    // R5 inhibit freezes
    csr_do(2'd1, 12'h320, 32'h1FD, 2'd3, 0, 0, 1'b0, "R5");
    csr_do(2'd0, 12'hB00, 0, 2'd3, 1, 32'd3, 1'b0, "R5 inhibit freeze");
    csr_do(2'd0, 12'hB00, 0, 2'd3, 1, 32'd3, 1'b0, "R5 inhibit freeze");

    // R2: retire counting
    csr_do(2'd1, 12'h320, 32'h1F9, 2'd3, 0, 0, 1'b0, "R2");
    csr_do(2'd1, 12'hB02, 32'h0, 2'd3, 0, 0, 1'b0, "R2");
    @(negedge clk) begin vld = 1'b0; ret = 2'd2; end
    @(negedge clk) ret = 2'd1;
    @(negedge clk) ret = 2'd0;
    @(negedge clk) ret = 2'd2;
    @(negedge clk) ret = 2'd0;
    csr_do(2'd0, 12'hB02, 0, 2'd3, 1, 32'd5, 1'b0, "R2 retire sum");
    csr_do(2'd0, 12'hB82, 0, 2'd3, 1, 32'd0, 1'b0, "R2 retire hi");

    // R3: event selection; counter 4 stays inhibited
    csr_do(2'd1, 12'h320, 32'h1F5, 2'd3, 0, 0, 1'b0, "R3");
    csr_do(2'd1, 12'h323, 32'd5, 2'd3, 0, 0, 1'b0, "R3");
    csr_do(2'd1, 12'h324, 32'd5, 2'd3, 0, 0, 1'b0, "R3");
    csr_do(2'd1, 12'hB03, 32'd0, 2'd3, 0, 0, 1'b0, "R3");
    idle(3, 22'h000011);
    idle(2, ~22'h000010);
    idle(1, 22'h0);
    csr_do(2'd0, 12'hB03, 0, 2'd3, 1, 32'd3, 1'b0, "R3 selected event count");
    csr_do(2'd0, 12'hB04, 0, 2'd3, 1, 32'd0, 1'b0, "R5 inhibited generic");

    // R4: reserved code and code 0 never count
    csr_do(2'd1, 12'h323, 32'd23, 2'd3, 0, 0, 1'b0, "R4");
    idle(3, 22'h3FFFFF);
    idle(1, 22'h0);
    csr_do(2'd0, 12'hB03, 0, 2'd3, 1, 32'd3, 1'b0, "R4 reserved code");
    csr_do(2'd1, 12'h323, 32'd0, 2'd3, 0, 0, 1'b0, "R4");
    idle(3, 22'h3FFFFF);
    idle(1, 22'h0);
    csr_do(2'd0, 12'hB03, 0, 2'd3, 1, 32'd3, 1'b0, "R4 code zero");

    // R7: write wins over a simultaneous event
    csr_do(2'd1, 12'h323, 32'd22, 2'd3, 0, 0, 1'b0, "R7");
    idle(2, 22'h200000);
    csr_do(2'd1, 12'hB03, 32'h50, 2'd3, 0, 0, 1'b0, "R7");
    idle(1, 22'h0);
    csr_do(2'd0, 12'hB03, 0, 2'd3, 1, 32'h50, 1'b0, "R7 event write priority");

    idle(1, 22'h0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(20 * 100000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule